// File: doc/BRIEF.md
# Serial ADC frame reader

This block is the host side of a read-only, three-wire link to a 14-bit successive-approximation converter. A one-cycle start request pulls chip select low. After a programmable setup interval the block makes 24 serial clock periods from a system-clock divider and samples the converter's data line as the serial clock rises. The serial clock idles low and the data is sampled on the leading edge.

Each frame carries 24 bits, MSB first:
- an 8-bit zero preamble;
- the 14 conversion bits;
- two trailing sub-bits.

The block discards the preamble. It registers the 14-bit result and the sub-bits, and it can also keep the full frame as three bytes. Chip select goes high on the 24th falling serial clock edge and then stays high for a minimum recovery interval before another frame may begin. An abort input ends a frame at once and throws away the partial capture.

All timing figures are whole system-clock counts. Elaboration checks compare them against the converter's minimum phase width, period, setup and chip-select high times.

Top module: `adc_frame_reader`

## Requirements
- R1: During and straight after reset, `cs_n_o` is 1 and `sclk_o`, `busy_o`, `valid_o`, `result_o`, `sub_o` and `frame_o` are all 0.
- R2: A start request seen while idle drives `cs_n_o` low on the next clock. The first rising edge of `sclk_o` comes exactly `SETUP_CYC` clocks after `cs_n_o` falls.
- R3: `sclk_o` is high for exactly `HALF_CYC` clocks and low for exactly `HALF_CYC` clocks. It is never high while `cs_n_o` is high. A frame has 24 rising edges, and `miso_i` is sampled on the clock that raises `sclk_o`.
- R4: `cs_n_o` goes high on the clock of the 24th falling `sclk_o` edge. It then stays high for at least `GAP_CYC`+1 clocks before it can fall again.
- R5: Of the 24 sampled bits (first sampled = bit 23), bits 23..16 are the preamble and have no effect on `result_o`. Bits 15..2 are D13..D0 and go to `result_o[13:0]`. Bits 1..0 are S1,S0 and go to `sub_o[1:0]`.
- R6: With `KEEP_BYTES`=1, `frame_o[23:16]` holds the first byte received, `frame_o[15:8]` the second and `frame_o[7:0]` the third, each MSB first.
- R7: `valid_o` is a single-clock pulse. It occurs in the same clock in which `result_o`, `sub_o` and `frame_o` take their new values and `cs_n_o` goes high. At all other times those outputs hold.
- R8: `busy_o` is high from the clock after the start request until the recovery interval ends. A start request while busy is ignored. A start held high begins the next frame on the first clock after busy falls.
- R9: An abort during setup or shifting raises `cs_n_o` and lowers `sclk_o` on the next clock. It produces no `valid_o` and leaves the previous result, sub-bits and frame unchanged. The recovery interval then applies.
- R10: An abort has no effect while idle or in the recovery interval, and a start request in the same clock as an abort is ignored. An abort in the clock of the 24th falling edge wins: no `valid_o` is produced.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| start_i | input | 1 | Request a frame when idle |
| abort_i | input | 1 | End the current frame at once |
| miso_i | input | 1 | Serial data from the converter |
| cs_n_o | output | 1 | Chip select to the converter, active low |
| sclk_o | output | 1 | Serial clock to the converter, idles low |
| busy_o | output | 1 | Frame or recovery interval in progress |
| valid_o | output | 1 | One-clock strobe on result update |
| result_o | output | DATA_BITS | Conversion result D13..D0 |
| sub_o | output | SUB_BITS | Trailing sub-bits S1,S0 |
| frame_o | output | PRE_BITS+DATA_BITS+SUB_BITS | Whole frame as three bytes (0 when not kept) |

## Verification
Two pairs of events can land in the same clock.

- **Abort and the final falling edge.** The bench raises abort in the exact clock in which the 24th falling edge of the serial clock is due. The bench's own timeline model expects chip select to rise with no valid strobe and with the old result kept.
- **End of recovery and a held start.** Start is held high across two frames. The model expects chip select to fall again one clock after busy drops. It also expects the second frame's result to be the new pattern, never a mix of the two.

// File: rtl/adc_rd_pkg.sv
`timescale 1ns/1ps
package adc_rd_pkg;

   typedef enum logic [1:0] {
      RD_IDLE  = 2'd0,
      RD_SETUP = 2'd1,
      RD_SHIFT = 2'd2,
      RD_GAP   = 2'd3
   } rd_state_e;

   // converter minimum timing, picoseconds
   localparam int unsigned PHASE_MIN_PS  = 65000;
   localparam int unsigned PERIOD_MIN_PS = 208000;
   localparam int unsigned SETUP_MIN_PS  = 100000;
   localparam int unsigned GAP_MIN_PS    = 50000;

endpackage

// File: rtl/rd_sclk_gen.sv
`timescale 1ns/1ps
module rd_sclk_gen #(
   parameter int unsigned HALF_CYC   = 21,
   parameter int unsigned FRAME_BITS = 24
) (
   input  logic clk,
   input  logic rst,
   input  logic launch_i,
   input  logic halt_i,
   output logic sclk_o,
   output logic rise_o,
   output logic fall_last_o
);
   localparam int unsigned HW = $clog2(HALF_CYC + 1);
   localparam int unsigned BW = $clog2(FRAME_BITS + 1);
   localparam logic [HW-1:0] HC_END = HW'(HALF_CYC - 1);
   localparam logic [BW-1:0] LAST_FALL = BW'(FRAME_BITS - 1);

   logic          running_q;
   logic          sclk_q;
   logic [HW-1:0] hc_q;
   logic [BW-1:0] nfall_q;
   logic          phase_end;
   logic          fall_now;

   assign phase_end   = running_q && (hc_q == HC_END);
   assign fall_now    = phase_end && sclk_q;
   assign rise_o      = launch_i || (phase_end && !sclk_q);
   assign fall_last_o = fall_now && (nfall_q == LAST_FALL);
   assign sclk_o      = sclk_q;

   always_ff @(posedge clk) begin
      if (rst || halt_i) begin
         running_q <= 1'b0;
         sclk_q    <= 1'b0;
         hc_q      <= '0;
         nfall_q   <= '0;
      end else if (launch_i) begin
         running_q <= 1'b1;
         sclk_q    <= 1'b1;
         hc_q      <= '0;
         nfall_q   <= '0;
      end else if (running_q) begin
         if (phase_end) begin
            sclk_q <= !sclk_q;
            hc_q   <= '0;
            if (sclk_q) nfall_q <= nfall_q + 1'b1;
         end else begin
            hc_q <= hc_q + 1'b1;
         end
      end
   end
endmodule

// File: rtl/rd_sequencer.sv
`timescale 1ns/1ps
module rd_sequencer import adc_rd_pkg::*; #(
   parameter int unsigned SETUP_CYC = 20,
   parameter int unsigned GAP_CYC   = 10
) (
   input  logic clk,
   input  logic rst,
   input  logic start_i,
   input  logic abort_i,
   input  logic fall_last_i,
   output logic cs_n_o,
   output logic busy_o,
   output logic launch_o,
   output logic halt_o,
   output logic done_o
);
   localparam int unsigned TMAX = (SETUP_CYC > GAP_CYC) ? SETUP_CYC : GAP_CYC;
   localparam int unsigned TW   = $clog2(TMAX + 1);
   localparam logic [TW-1:0] SU_END = TW'(SETUP_CYC - 1);
   localparam logic [TW-1:0] GP_END = TW'(GAP_CYC - 1);

   rd_state_e     st_q;
   logic [TW-1:0] t_q;
   logic          cs_n_q;
   logic          active;

   assign active   = (st_q == RD_SETUP) || (st_q == RD_SHIFT);
   assign launch_o = (st_q == RD_SETUP) && (t_q == SU_END) && !abort_i;
   assign halt_o   = (active && abort_i) || ((st_q == RD_SHIFT) && fall_last_i);
   assign done_o   = (st_q == RD_SHIFT) && fall_last_i && !abort_i;
   assign busy_o   = (st_q != RD_IDLE);
   assign cs_n_o   = cs_n_q;

   always_ff @(posedge clk) begin
      if (rst) begin
         st_q   <= RD_IDLE;
         t_q    <= '0;
         cs_n_q <= 1'b1;
      end else begin
         case (st_q)
            RD_IDLE: begin
               if (start_i && !abort_i) begin
                  st_q   <= RD_SETUP;
                  t_q    <= '0;
                  cs_n_q <= 1'b0;
               end
            end
            RD_SETUP: begin
               if (abort_i) begin
                  st_q   <= RD_GAP;
                  t_q    <= '0;
                  cs_n_q <= 1'b1;
               end else if (t_q == SU_END) begin
                  st_q <= RD_SHIFT;
                  t_q  <= '0;
               end else begin
                  t_q <= t_q + 1'b1;
               end
            end
            RD_SHIFT: begin
               if (abort_i || fall_last_i) begin
                  st_q   <= RD_GAP;
                  t_q    <= '0;
                  cs_n_q <= 1'b1;
               end
            end
            RD_GAP: begin
               if (t_q == GP_END) st_q <= RD_IDLE;
               else               t_q  <= t_q + 1'b1;
            end
            default: st_q <= RD_IDLE;
         endcase
      end
   end
endmodule

// File: rtl/rd_capture.sv
`timescale 1ns/1ps
module rd_capture #(
   parameter int unsigned DATA_BITS  = 14,
   parameter int unsigned SUB_BITS   = 2,
   parameter int unsigned FRAME_BITS = 24,
   parameter bit          KEEP_BYTES = 1'b1
) (
   input  logic                  clk,
   input  logic                  rst,
   input  logic                  rise_i,
   input  logic                  done_i,
   input  logic                  miso_i,
   output logic                  valid_o,
   output logic [DATA_BITS-1:0]  result_o,
   output logic [SUB_BITS-1:0]   sub_o,
   output logic [FRAME_BITS-1:0] frame_o
);
   logic [FRAME_BITS-1:0] shreg_q;

   always_ff @(posedge clk) begin
      if (rst)         shreg_q <= '0;
      else if (rise_i) shreg_q <= {shreg_q[FRAME_BITS-2:0], miso_i};
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         valid_o  <= 1'b0;
         result_o <= '0;
         sub_o    <= '0;
      end else begin
         valid_o <= done_i;
         if (done_i) begin
            result_o <= shreg_q[SUB_BITS +: DATA_BITS];
            sub_o    <= shreg_q[SUB_BITS-1:0];
         end
      end
   end

   generate
      if (KEEP_BYTES) begin : g_keep_frame
         logic [FRAME_BITS-1:0] frame_q;
         always_ff @(posedge clk) begin
            if (rst)         frame_q <= '0;
            else if (done_i) frame_q <= shreg_q;
         end
         assign frame_o = frame_q;
      end else begin : g_drop_frame
         assign frame_o = '0;
      end
   endgenerate
endmodule

// File: rtl/adc_frame_reader.sv
`timescale 1ns/1ps
module adc_frame_reader import adc_rd_pkg::*; #(
   parameter int unsigned CLK_PS     = 5000,
   parameter int unsigned HALF_CYC   = 21,
   parameter int unsigned SETUP_CYC  = 20,
   parameter int unsigned GAP_CYC    = 10,
   parameter int unsigned PRE_BITS   = 8,
   parameter int unsigned DATA_BITS  = 14,
   parameter int unsigned SUB_BITS   = 2,
   parameter bit          KEEP_BYTES = 1'b1
) (
   input  logic                                     clk,
   input  logic                                     rst,
   input  logic                                     start_i,
   input  logic                                     abort_i,
   input  logic                                     miso_i,
   output logic                                     cs_n_o,
   output logic                                     sclk_o,
   output logic                                     busy_o,
   output logic                                     valid_o,
   output logic [DATA_BITS-1:0]                     result_o,
   output logic [SUB_BITS-1:0]                      sub_o,
   output logic [PRE_BITS+DATA_BITS+SUB_BITS-1:0]   frame_o
);
   localparam int unsigned FRAME_BITS = PRE_BITS + DATA_BITS + SUB_BITS;

   generate
      if (HALF_CYC * CLK_PS < PHASE_MIN_PS) begin : g_err_phase
         $error("serial clock phase below converter minimum");
      end
      if (2 * HALF_CYC * CLK_PS < PERIOD_MIN_PS) begin : g_err_period
         $error("serial clock period below converter minimum");
      end
      if (SETUP_CYC * CLK_PS < SETUP_MIN_PS || SETUP_CYC < 1) begin : g_err_setup
         $error("chip select setup below converter minimum");
      end
      if (GAP_CYC * CLK_PS < GAP_MIN_PS || GAP_CYC < 1) begin : g_err_gap
         $error("chip select high time below converter minimum");
      end
      if (SUB_BITS < 1 || DATA_BITS < 1) begin : g_err_fields
         $error("data and sub-bit fields must be non-empty");
      end
      if (KEEP_BYTES && (FRAME_BITS % 8 != 0)) begin : g_err_bytes
         $error("byte capture needs a frame that is a whole number of bytes");
      end
   endgenerate

   logic launch;
   logic halt;
   logic done;
   logic rise;
   logic fall_last;

   rd_sequencer #(
      .SETUP_CYC (SETUP_CYC),
      .GAP_CYC   (GAP_CYC)
   ) u_seq (
      .clk         (clk),
      .rst         (rst),
      .start_i     (start_i),
      .abort_i     (abort_i),
      .fall_last_i (fall_last),
      .cs_n_o      (cs_n_o),
      .busy_o      (busy_o),
      .launch_o    (launch),
      .halt_o      (halt),
      .done_o      (done)
   );

   rd_sclk_gen #(
      .HALF_CYC   (HALF_CYC),
      .FRAME_BITS (FRAME_BITS)
   ) u_sclk (
      .clk         (clk),
      .rst         (rst),
      .launch_i    (launch),
      .halt_i      (halt),
      .sclk_o      (sclk_o),
      .rise_o      (rise),
      .fall_last_o (fall_last)
   );

   rd_capture #(
      .DATA_BITS  (DATA_BITS),
      .SUB_BITS   (SUB_BITS),
      .FRAME_BITS (FRAME_BITS),
      .KEEP_BYTES (KEEP_BYTES)
   ) u_cap (
      .clk      (clk),
      .rst      (rst),
      .rise_i   (rise),
      .done_i   (done),
      .miso_i   (miso_i),
      .valid_o  (valid_o),
      .result_o (result_o),
      .sub_o    (sub_o),
      .frame_o  (frame_o)
   );
endmodule

// File: rtl/adc_frame_reader_chk.sv
`timescale 1ns/1ps
module adc_frame_reader_chk #(
   parameter int unsigned HALF_CYC  = 21,
   parameter int unsigned GAP_CYC   = 10,
   parameter int unsigned DATA_BITS = 14,
   parameter int unsigned SUB_BITS  = 2
) (
   input logic                 clk,
   input logic                 rst,
   input logic                 abort_i,
   input logic                 cs_n_o,
   input logic                 sclk_o,
   input logic                 busy_o,
   input logic                 valid_o,
   input logic [DATA_BITS-1:0] result_o,
   input logic [SUB_BITS-1:0]  sub_o
);
   localparam int unsigned HRW = $clog2(HALF_CYC + 2);
   localparam int unsigned GRW = $clog2(GAP_CYC + 3);
   localparam logic [GRW-1:0] GAP_SAT = GRW'(GAP_CYC + 2);
   localparam logic [GRW-1:0] GAP_OK  = GRW'(GAP_CYC + 1);

   logic [HRW-1:0] hi_run;
   logic [GRW-1:0] gap_run;

   always_ff @(posedge clk) begin
      if (rst)         hi_run <= '0;
      else if (sclk_o) hi_run <= hi_run + 1'b1;
      else             hi_run <= '0;
   end

   always_ff @(posedge clk) begin
      if (rst)                    gap_run <= GAP_OK;
      else if (!cs_n_o)           gap_run <= '0;
      else if (gap_run != GAP_SAT) gap_run <= gap_run + 1'b1;
   end

   assert_sclk_in_frame_R3: assert property (@(posedge clk) disable iff (rst)
      sclk_o |-> !cs_n_o);

   assert_high_phase_R3: assert property (@(posedge clk) disable iff (rst)
      ($fell(sclk_o) && !$past(abort_i)) |-> (hi_run == HRW'(HALF_CYC)));

   assert_cs_high_time_R4: assert property (@(posedge clk) disable iff (rst)
      $fell(cs_n_o) |-> (gap_run >= GAP_OK));

   assert_valid_pulse_R7: assert property (@(posedge clk) disable iff (rst)
      valid_o |=> !valid_o);

   assert_valid_on_cs_rise_R7: assert property (@(posedge clk) disable iff (rst)
      valid_o |-> (cs_n_o && !$past(cs_n_o)));

   assert_result_hold_R7: assert property (@(posedge clk) disable iff (rst)
      !valid_o |-> ($stable(result_o) && $stable(sub_o)));

   assert_idle_quiet_R8: assert property (@(posedge clk) disable iff (rst)
      !busy_o |-> (cs_n_o && !sclk_o));

   assert_abort_stops_R9: assert property (@(posedge clk) disable iff (rst)
      (abort_i && !cs_n_o) |=> (cs_n_o && !sclk_o && !valid_o));
endmodule

bind adc_frame_reader adc_frame_reader_chk #(
   .HALF_CYC  (HALF_CYC),
   .GAP_CYC   (GAP_CYC),
   .DATA_BITS (DATA_BITS),
   .SUB_BITS  (SUB_BITS)
) u_chk (
   .clk      (clk),
   .rst      (rst),
   .abort_i  (abort_i),
   .cs_n_o   (cs_n_o),
   .sclk_o   (sclk_o),
   .busy_o   (busy_o),
   .valid_o  (valid_o),
   .result_o (result_o),
   .sub_o    (sub_o)
);

// File: tb/adc_frame_reader_tb.sv
`timescale 1ns/1ps
module adc_frame_reader_tb;
   localparam int HALF  = 21;
   localparam int SETUP = 20;
   localparam int GAP   = 10;
   localparam int DB    = 14;
   localparam int SB    = 2;
   localparam int FB    = 24;
   localparam int MEND  = SETUP + 1 + (2 * FB - 1) * HALF;

   logic clk = 1'b0;
   logic rst = 1'b1;
   logic start = 1'b0;
   logic abort = 1'b0;
   logic miso;
   logic cs_n, sclk, busy, valid;
   logic [DB-1:0] result;
   logic [SB-1:0] sub;
   logic [FB-1:0] frame;

   int total = 0;
   int bad = 0;

   always #2.5 clk = ~clk;

   adc_frame_reader u_dut (
      .clk (clk), .rst (rst), .start_i (start), .abort_i (abort), .miso_i (miso),
      .cs_n_o (cs_n), .sclk_o (sclk), .busy_o (busy), .valid_o (valid),
      .result_o (result), .sub_o (sub), .frame_o (frame)
   );

   // converter model: MSB presented at chip select fall, next bit after each falling edge
   logic [FB-1:0] pat = '0;
   int idx = FB - 1;
   always @(negedge cs_n) idx = FB - 1;
   always @(negedge sclk) if (cs_n === 1'b0) idx = idx - 1;
   assign miso = (cs_n === 1'b0 && idx >= 0) ? pat[idx] : 1'b0;

   // timeline reference model: mk counts clocks since the start was taken
   int mk = 0;
   int mend = 0;
   bit aborted = 0;
   logic [DB-1:0] e_res = '0;
   logic [SB-1:0] e_sub = '0;
   logic [FB-1:0] e_frame = '0;

   always @(posedge clk) begin
      if (rst) begin
         mk = 0; mend = 0; aborted = 0;
         e_res = '0; e_sub = '0; e_frame = '0;
      end else if (mk == 0) begin
         if (start && !abort) begin
            mk = 1; mend = MEND; aborted = 0;
         end
      end else begin
         if (abort && mk < mend) begin
            mend = mk + 1;
            aborted = 1;
         end else if (!aborted && mk + 1 == mend) begin
            e_res = pat[SB +: DB];
            e_sub = pat[SB-1:0];
            e_frame = pat;
         end
         mk = mk + 1;
         if (mk == mend + GAP) mk = 0;
      end
   end

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s act=%0h exp=%0h at %0t", tag, act, exp, $time);
      end
   endtask

   always @(negedge clk) begin
      if (!rst) begin
         bit act;
         bit e_sclk;
         act = (mk >= 1) && (mk < mend);
         e_sclk = act && (mk >= SETUP + 1) && (((mk - SETUP - 1) % (2 * HALF)) < HALF);
         chk("R4 cs_n", 32'(cs_n), 32'(!act));
         chk("R3 sclk", 32'(sclk), 32'(e_sclk));
         chk("R8 busy", 32'(busy), 32'(mk != 0));
         chk("R7 valid", 32'(valid), 32'(mk != 0 && mk == mend && !aborted));
         chk("R5 result", 32'(result), 32'(e_res));
         chk("R5 sub", 32'(sub), 32'(e_sub));
         chk("R6 frame", 32'(frame), 32'(e_frame));
      end
   end

   task automatic wait_idle();
      while (mk != 0) @(negedge clk);
      repeat (3) @(negedge clk);
   endtask

   task automatic frame_run(input logic [FB-1:0] p);
      pat = p;
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      wait_idle();
   endtask

   task automatic abort_at(input int when_k, input logic [FB-1:0] p);
      pat = p;
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      while (mk != when_k) @(negedge clk);
      abort = 1'b1;
      @(negedge clk);
      abort = 1'b0;
      chk("R9 cs_n high after abort", 32'(cs_n), 32'd1);
      chk("R9 sclk low after abort", 32'(sclk), 32'd0);
      chk("R9 no valid after abort", 32'(valid), 32'd0);
      wait_idle();
   endtask

   task automatic run_all();
      repeat (3) @(negedge clk);
      // R1 reset state
      chk("R1 cs_n", 32'(cs_n), 32'd1);
      chk("R1 sclk", 32'(sclk), 32'd0);
      chk("R1 busy", 32'(busy), 32'd0);
      chk("R1 valid", 32'(valid), 32'd0);
      chk("R1 result", 32'(result), 32'd0);
      rst = 1'b0;
      repeat (2) @(negedge clk);
      chk("R1 cs_n after release", 32'(cs_n), 32'd1);

      // R2 setup timing on the first frame
      pat = 24'h00A972;
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      chk("R2 cs_n falls", 32'(cs_n), 32'd0);
      chk("R8 busy rises", 32'(busy), 32'd1);
      repeat (SETUP - 1) @(negedge clk);
      chk("R2 sclk low before setup ends", 32'(sclk), 32'd0);
      @(negedge clk);
      chk("R2 first rising edge", 32'(sclk), 32'd1);
      wait_idle();
      chk("R5 result 2A5C", 32'(result), 32'h2A5C);
      chk("R5 sub 10", 32'(sub), 32'h2);
      chk("R6 frame bytes", 32'(frame), 32'h00A972);

      frame_run(24'h00FFFF);
      chk("R5 all ones", 32'(result), 32'h3FFF);
      chk("R5 sub ones", 32'(sub), 32'h3);

      // R5 preamble content ignored, R6 still shows it
      frame_run(24'hA50005);
      chk("R5 preamble ignored", 32'(result), 32'h0001);
      chk("R6 first byte kept", 32'(frame[23:16]), 32'hA5);

      // R8 start held high across two frames
      pat = 24'h0048D0;
      start = 1'b1;
      @(negedge clk);
      while (mk != MEND) @(negedge clk);
      chk("R8 first of pair", 32'(result), 32'h1234);
      pat = 24'h003C3F;
      while (mk != 0) @(negedge clk);
      @(negedge clk);
      chk("R8 back-to-back restart", 32'(cs_n), 32'd0);
      start = 1'b0;
      wait_idle();
      chk("R8 second of pair", 32'(result), 32'h0F0F);

      // R9 aborts in setup and mid-shift
      abort_at(5, 24'h00FFFF);
      chk("R9 result kept after setup abort", 32'(result), 32'h0F0F);
      abort_at(300, 24'h00FFFF);
      chk("R9 result kept after shift abort", 32'(result), 32'h0F0F);
      chk("R9 frame kept after shift abort", 32'(frame), 32'h003C3F);
      // R10 abort in the final falling-edge clock wins
      abort_at(MEND - 1, 24'h00FFFF);
      chk("R10 abort at last edge", 32'(result), 32'h0F0F);

      frame_run(24'h000000);
      chk("R5 zeros", 32'(result), 32'h0000);

      // R8 start while busy ignored; R10 abort in recovery has no effect
      pat = 24'h008001;
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      while (mk != 100) @(negedge clk);
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      while (mk != MEND + 2) @(negedge clk);
      abort = 1'b1;
      @(negedge clk);
      abort = 1'b0;
      chk("R10 busy through gap abort", 32'(busy), 32'd1);
      wait_idle();
      chk("R10 result after gap abort", 32'(result), 32'h2000);
      chk("R10 sub after gap abort", 32'(sub), 32'h1);

      // R10 start together with abort while idle
      start = 1'b1;
      abort = 1'b1;
      @(negedge clk);
      start = 1'b0;
      abort = 1'b0;
      @(negedge clk);
      chk("R10 start with abort ignored busy", 32'(busy), 32'd0);
      chk("R10 start with abort ignored cs_n", 32'(cs_n), 32'd1);
      repeat (5) @(negedge clk);
   endtask

   initial begin
      fork
         run_all();
         begin
            repeat (150000) @(posedge clk);
            total++;
            bad++;
            $display("FAIL R8 watchdog act=hung exp=idle");
         end
      join_any
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule